// File: doc/BRIEF.md
# Dual-Channel Acquisition Capture Buffer

This block sits between two 8-bit sample streams and a slow processor bus. It has one first-in first-out store per channel. Both stores are written at the same moments by a write strobe. The strobe is derived from an incoming sample tick, divided down by a 2-bit rate select. The processor side drains the stores one byte at a time. It issues a single-cycle read strobe together with a read enable and a 2-bit channel select, and the selected byte appears on a shared output register.

Each acquisition is one-shot. A clear empties both stores, restarts the rate divider and arms the capture. A channel takes samples until its store becomes full. From then on it takes no more samples, even if reads free space, until the next clear. A capture-done flag rises once both channels have filled and stays high until the clear. Write and read sides share one clock, so the only rate difference is how often each side is strobed.

Top module: `capbuf_dual`

## Requirements
- R1: After reset both stores are empty and not full, `capture_done` is low and `rd_data` is 0.
- R2: With rate select s, only sample ticks whose index since the last clear or reset is a multiple of 2^s (s = 0..3: every tick, every 2nd, 4th, 8th) are stored. The first tick after a clear is always stored.
- R3: A channel whose store holds DEPTH entries (full flag high) stores no further samples. The data read back is the first DEPTH stored samples, in order.
- R4: Once a channel has filled, it stays frozen: reads that free space do not let new samples in until a clear.
- R5: A read directed at an empty channel has no effect. `rd_data` and all flags stay unchanged.
- R6: A read takes effect only when `rd_stb` and `rd_en` are both high. The oldest byte of the selected channel appears on `rd_data` one cycle after the strobe. `rd_data` then holds that value until the next accepted read.
- R7: Channel select 00 reads channel 0 and 01 reads channel 1. Values 10 and 11 select no channel, and a read with them changes nothing.
- R8: `capture_done` rises in the cycle after the later of the two channels fills. It stays high, through reads, until a clear.
- R9: A clear, which takes priority over a read or write in the same cycle, leaves both stores empty, `capture_done` low and the divider phase restarted. `rd_data` is not altered by the clear.
- R10: Both channels store a sample on the same write strobe, each from its own data input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear and rearm of both stores |
| smp_tick | input | 1 | One pulse per ADC sample |
| dec_sel | input | 2 | Rate select: store every 2^dec_sel-th tick |
| ch0_din | input | 8 | Channel 0 sample |
| ch1_din | input | 8 | Channel 1 sample |
| rd_stb | input | 1 | Single-cycle read strobe from the processor side |
| rd_en | input | 1 | Read enable, qualifies rd_stb |
| rd_sel | input | 2 | Channel select for reads |
| rd_data | output | 8 | Last byte read |
| ch0_empty | output | 1 | Channel 0 store holds nothing |
| ch0_full | output | 1 | Channel 0 store holds DEPTH entries |
| ch1_empty | output | 1 | Channel 1 store holds nothing |
| ch1_full | output | 1 | Channel 1 store holds DEPTH entries |
| capture_done | output | 1 | Both channels have filled since the last clear |

## Verification
The bench builds the block with DEPTH set to 16 and the rate select kept 2 bits wide. This lets a full-and-freeze episode, draining past empty and a refill after a clear each happen within a few dozen cycles. With the full 3-bit divider reachable, every rate setting is tried, including changes of rate in the middle of a capture. A behavioural queue model predicts every flag and `rd_data` each cycle. Reads are interleaved with writes, so pop-and-push in the same cycle at the fill boundary is covered.

// File: rtl/capbuf_pkg.sv
package capbuf_pkg;

   // read channel select encoding
   typedef enum logic [1:0] {
      CHSEL_A  = 2'd0,
      CHSEL_B  = 2'd1,
      CHSEL_R2 = 2'd2,
      CHSEL_R3 = 2'd3
   } chsel_e;

   localparam int unsigned NUM_CH = 2;

   // largest divide exponent reachable by a rate select of the given width
   function automatic int unsigned max_div_log(input int unsigned sel_w);
      return (1 << sel_w) - 1;
   endfunction

endpackage

// File: rtl/capbuf_rate.sv
module capbuf_rate #(
   parameter int unsigned DEC_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             smp_tick,
   input  logic [DEC_W-1:0] dec_sel,
   output logic             wr_go
);
   import capbuf_pkg::*;

   localparam int unsigned MAXLOG = max_div_log(DEC_W);
   localparam int unsigned CW     = (MAXLOG > 0) ? MAXLOG : 1;

   initial begin : elab_chk
      assert (DEC_W >= 1 && DEC_W <= 3)
         else $error("capbuf_rate: DEC_W must be 1..3");
   end

   logic [CW-1:0] phase;
   logic [CW-1:0] mask;

   assign mask  = CW'((32'd1 << dec_sel) - 32'd1);
   assign wr_go = smp_tick && ((phase & mask) == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= '0;
      end else if (clr) begin
         phase <= '0;
      end else if (smp_tick) begin
         phase <= phase + 1'b1;
      end
   end

   // R2: strobe only on a sample tick whose phase matches the divider
   assert_strobe_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_sel != '0 && smp_tick && !clr && wr_go) |=> !wr_go || !smp_tick || (dec_sel != $past(dec_sel)));

endmodule

// File: rtl/capbuf_fifo.sv
module capbuf_fifo #(
   parameter int unsigned DW    = 8,
   parameter int unsigned DEPTH = 512
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          wr_go,
   input  logic [DW-1:0] din,
   input  logic          rd_go,
   output logic [DW-1:0] head,
   output logic          empty,
   output logic          full,
   output logic          frozen
);
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = AW + 1;

   initial begin : elab_chk
      assert (DEPTH >= 2) else $error("capbuf_fifo: DEPTH must be at least 2");
      assert (DW >= 1)    else $error("capbuf_fifo: DW must be at least 1");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wptr, rptr, wnxt, rnxt;
   logic [CW-1:0] count, count_nxt;
   logic          stop;
   logic          wr_ok, rd_ok;

   // pointer advance: free wrap for power-of-two depth, compare otherwise
   generate
      if (DEPTH == (1 << AW)) begin : g_pow2
         assign wnxt = wptr + 1'b1;
         assign rnxt = rptr + 1'b1;
      end else begin : g_wrap
         assign wnxt = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
         assign rnxt = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      end
   endgenerate

   assign wr_ok     = wr_go && !stop;
   assign rd_ok     = rd_go && (count != '0);
   assign count_nxt = count + CW'(wr_ok) - CW'(rd_ok);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
         stop  <= 1'b0;
      end else if (clr) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
         stop  <= 1'b0;
      end else begin
         if (wr_ok) wptr <= wnxt;
         if (rd_ok) rptr <= rnxt;
         count <= count_nxt;
         if (wr_ok && count_nxt == CW'(DEPTH)) stop <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_ok && !clr) mem[wptr] <= din;
   end

   assign head   = mem[rptr];
   assign empty  = (count == '0);
   assign full   = (count == CW'(DEPTH));
   assign frozen = stop;

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr_go && !clr) |=> $stable(wptr));

   assert_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !clr) |=> (count <= $past(count)));

   assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && rd_go && !clr) |=> $stable(rptr));

   assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (empty && !stop));

endmodule

// File: rtl/capbuf_dual.sv
module capbuf_dual #(
   parameter int unsigned DW    = 8,
   parameter int unsigned DEPTH = 512,
   parameter int unsigned DEC_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             smp_tick,
   input  logic [DEC_W-1:0] dec_sel,
   input  logic [DW-1:0]    ch0_din,
   input  logic [DW-1:0]    ch1_din,
   input  logic             rd_stb,
   input  logic             rd_en,
   input  logic [1:0]       rd_sel,
   output logic [DW-1:0]    rd_data,
   output logic             ch0_empty,
   output logic             ch0_full,
   output logic             ch1_empty,
   output logic             ch1_full,
   output logic             capture_done
);
   import capbuf_pkg::*;

   logic          wr_go;
   logic [DW-1:0] din_a  [NUM_CH];
   logic [DW-1:0] head_a [NUM_CH];
   logic [NUM_CH-1:0] rd_req, emp, ful, frz;
   logic          rd_acc;
   chsel_e        sel_e;

   assign din_a[0] = ch0_din;
   assign din_a[1] = ch1_din;
   assign sel_e    = chsel_e'(rd_sel);

   capbuf_rate #(.DEC_W(DEC_W)) u_rate (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .smp_tick (smp_tick),
      .dec_sel  (dec_sel),
      .wr_go    (wr_go)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         assign rd_req[c] = rd_stb && rd_en && (sel_e == chsel_e'(2'(c)));

         capbuf_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (clr),
            .wr_go  (wr_go),
            .din    (din_a[c]),
            .rd_go  (rd_req[c]),
            .head   (head_a[c]),
            .empty  (emp[c]),
            .full   (ful[c]),
            .frozen (frz[c])
         );
      end
   endgenerate

   assign rd_acc = |(rd_req & ~emp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (!clr && rd_acc) begin
         rd_data <= rd_sel[0] ? head_a[1] : head_a[0];
      end
   end

   assign ch0_empty    = emp[0];
   assign ch0_full     = ful[0];
   assign ch1_empty    = emp[1];
   assign ch1_full     = ful[1];
   assign capture_done = &frz;

   assert_done_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (capture_done && !clr) |=> capture_done);

   assert_done_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(capture_done) |-> (ch0_full || ch1_full));

   assert_reserved_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && rd_sel[1] && !clr) |=> $stable(rd_data));

   assert_clear_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !capture_done);

endmodule

// File: tb/sim_capbuf_dual.sv
module sim_capbuf_dual;
   localparam int CLK_P = 10;
   localparam int DEPTH = 16;
   localparam int DW    = 8;

   logic clk = 1'b0;
   always #(CLK_P/2) clk = ~clk;

   logic          rst_n, clr, smp_tick, rd_stb, rd_en;
   logic [1:0]    dec_sel, rd_sel;
   logic [DW-1:0] ch0_din, ch1_din, rd_data;
   logic          ch0_empty, ch0_full, ch1_empty, ch1_full, capture_done;

   capbuf_dual #(.DW(DW), .DEPTH(DEPTH), .DEC_W(2)) u0 (
      .clk(clk), .rst_n(rst_n), .clr(clr), .smp_tick(smp_tick), .dec_sel(dec_sel),
      .ch0_din(ch0_din), .ch1_din(ch1_din), .rd_stb(rd_stb), .rd_en(rd_en),
      .rd_sel(rd_sel), .rd_data(rd_data), .ch0_empty(ch0_empty), .ch0_full(ch0_full),
      .ch1_empty(ch1_empty), .ch1_full(ch1_full), .capture_done(capture_done)
   );

   int    checks = 0;
   int    errors = 0;
   bit    finished = 0;
   string req = "R1";

   logic [DW-1:0] q0[$];
   logic [DW-1:0] q1[$];
   bit            st0, st1;
   int            dcnt;
   logic [DW-1:0] exp_rd;
   logic [DW-1:0] dval;

   task automatic chk(bit ok, string tag, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   // behavioural reference, applied with the inputs seen at the clock edge
   task automatic model();
      bit go;
      int n;
      if (!rst_n) begin
         q0.delete(); q1.delete(); st0 = 0; st1 = 0; dcnt = 0; exp_rd = '0;
      end else if (clr) begin
         q0.delete(); q1.delete(); st0 = 0; st1 = 0; dcnt = 0;
      end else begin
         if (rd_stb && rd_en && rd_sel == 2'd0 && q0.size() > 0) exp_rd = q0.pop_front();
         else if (rd_stb && rd_en && rd_sel == 2'd1 && q1.size() > 0) exp_rd = q1.pop_front();
         n  = 1 << dec_sel;
         go = smp_tick && (dcnt % n == 0);
         if (smp_tick) dcnt = (dcnt + 1) % 8;
         if (go && !st0) begin q0.push_back(ch0_din); if (q0.size() == DEPTH) st0 = 1; end
         if (go && !st1) begin q1.push_back(ch1_din); if (q1.size() == DEPTH) st1 = 1; end
      end
   endtask

   task automatic compare();
      chk(ch0_empty == (q0.size() == 0), req, "ch0_empty", ch0_empty, q0.size() == 0);
      chk(ch1_empty == (q1.size() == 0), req, "ch1_empty", ch1_empty, q1.size() == 0);
      chk(ch0_full == (q0.size() == DEPTH), req, "ch0_full", ch0_full, q0.size() == DEPTH);
      chk(ch1_full == (q1.size() == DEPTH), req, "ch1_full", ch1_full, q1.size() == DEPTH);
      chk(capture_done == (st0 && st1), req, "capture_done", capture_done, st0 && st1);
      chk(rd_data === exp_rd, req, "rd_data", rd_data, exp_rd);
   endtask

   task automatic cyc();
      @(posedge clk);
      model();
      #1;
      compare();
   endtask

   task automatic quiet();
      clr = 0; smp_tick = 0; rd_stb = 0; rd_en = 0;
   endtask

   task automatic samples(int n, bit every);
      for (int i = 0; i < n; i++) begin
         quiet();
         smp_tick = every ? 1'b1 : (i % 3 != 2);
         ch0_din  = dval;
         ch1_din  = dval ^ 8'hA5;
         dval     = dval + 8'd7;
         cyc();
      end
      quiet();
   endtask

   task automatic rd(logic [1:0] sel, bit en);
      quiet();
      rd_stb = 1; rd_en = en; rd_sel = sel;
      cyc();
      quiet();
      cyc();
   endtask

   task automatic do_clear();
      quiet(); clr = 1; cyc(); quiet(); cyc();
   endtask

   initial begin
      rst_n = 0; dval = 8'd3; dec_sel = 2'd0; rd_sel = 2'd0; ch0_din = '0; ch1_din = '0;
      quiet();
      cyc(); cyc();
      rst_n = 1;
      // R1: reset state
      cyc();
      chk(ch0_empty && ch1_empty && !ch0_full && !ch1_full, "R1", "flags after reset",
          {ch0_empty, ch1_empty, ch0_full, ch1_full}, 4'b1100);
      chk(rd_data == 0 && !capture_done, "R1", "rd_data/done after reset", rd_data, 0);

      // R10 and R6: both channels written together, read back in order
      req = "R10"; samples(5, 1);
      req = "R6";
      rd(2'd0, 1'b0);
      chk(rd_data == 0, "R6", "read without enable ignored", rd_data, 0);
      for (int i = 0; i < 3; i++) rd(2'd0, 1'b1);
      for (int i = 0; i < 3; i++) rd(2'd1, 1'b1);
      req = "R7"; rd(2'd2, 1'b1); rd(2'd3, 1'b1);
      chk(rd_data == exp_rd, "R7", "reserved select leaves rd_data", rd_data, exp_rd);

      // R9 clear, then R2 every rate with gapped ticks
      req = "R9"; do_clear();
      chk(ch0_empty && ch1_empty && !capture_done, "R9", "clear empties", ch0_empty, 1);
      for (int s = 0; s < 4; s++) begin
         req = "R2"; dec_sel = 2'(s);
         samples(19, s[0]);
         for (int i = 0; i < DEPTH; i++) begin rd(2'd0, 1'b1); rd(2'd1, 1'b1); end
         req = "R9"; do_clear();
      end
      req = "R2"; dec_sel = 2'd1; samples(5, 1); dec_sel = 2'd2; samples(9, 1);
      do_clear();

      // R3/R8: fill both, extra samples dropped
      dec_sel = 2'd0;
      req = "R3"; samples(DEPTH + 6, 1);
      chk(ch0_full && ch1_full, "R3", "both full", ch0_full, 1);
      req = "R8";
      chk(capture_done == 1, "R8", "done after fill", capture_done, 1);
      // R4: free space, samples must not enter
      req = "R4"; rd(2'd0, 1'b1); rd(2'd0, 1'b1); samples(4, 1);
      chk(!ch0_full && capture_done, "R4", "frozen after read", ch0_full, 0);
      // R5: drain channel 0 past empty
      for (int i = 0; i < DEPTH + 2; i++) rd(2'd0, 1'b1);
      req = "R5"; rd(2'd0, 1'b1);
      chk(ch0_empty && rd_data == exp_rd, "R5", "empty read no effect", rd_data, exp_rd);
      req = "R9"; do_clear();
      chk(!capture_done, "R9", "done cleared", capture_done, 0);

      // R8 with uneven fill: reads on channel 1 while filling
      req = "R8"; dec_sel = 2'd1;
      for (int k = 0; k < 12; k++) begin
         samples(4, 1);
         quiet(); rd_stb = 1; rd_en = 1; rd_sel = 2'd1; smp_tick = 1;
         ch0_din = dval; ch1_din = ~dval; dval = dval + 8'd1;
         cyc(); quiet();
      end
      samples(30, 1);
      chk(capture_done == (st0 && st1), "R8", "done after uneven fill", capture_done, st0 && st1);
      // R9: clear in the same cycle as a read and a tick
      quiet(); clr = 1; rd_stb = 1; rd_en = 1; rd_sel = 2'd1; smp_tick = 1; req = "R9";
      cyc(); quiet(); cyc();
      chk(ch1_empty && !capture_done, "R9", "clear wins", ch1_empty, 1);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not complete actual=0 expected=1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule